// File: doc/BRIEF.md
# Up-Counting Interval Timer with Posted Register Writes

This block is a 32-bit interval timer that sits on a simple word-aligned register bus. It holds a counter that only counts up, a reload word, a compare word and a control word. Software loads the counter with the two's-complement negative of an interval, starts the timer, and gets an overflow event when the counter wraps past all-ones. An optional auto-reload puts the reload word into the counter at each wrap. A power-of-two prescaler can slow the count rate. A compare function can flag the moment the counter reaches a chosen value.

The timer logic runs on the bus clock, but it only acts on cycles where `tick_en` is high. This models a slow timer clock. Writes to the control, counter, reload, trigger and compare registers are posted. The new value is held, and it takes effect only after a fixed number of ticks. Until then, a per-register bit in the write-pending register stays set, and software polls that bit before relying on the new value. The event status and the interrupt enable registers act at once. Status bits are cleared by writing ones, so writing back a value just read clears exactly the events seen.

Top module: `uptick_timer`

## Requirements
- R1: A read of offset 0x000 returns the revision byte, with the major number in bits 7:4 and the minor number in bits 3:0. With default parameters this is 0x21. All higher bits read as zero.
- R2: A write to control (0x024), counter (0x028), reload (0x02C), trigger (0x030) or compare (0x038) is posted.
  - The register keeps its old value until the POST_TICKS-th tick after the write. POST_TICKS is 3 by default.
  - While the write is held, the matching bit of the pending register (0x034) reads 1. Bit 0 is control, bit 1 counter, bit 2 reload, bit 3 trigger and bit 4 compare.
  - The pending bit clears on the tick that applies the write.
- R3: A second write to a register whose write is still pending replaces the held value and restarts that register's full tick delay.
- R4: When control bit 0 is 1, the counter advances by one per count step. When bit 0 is 0, the counter holds its value unless a posted counter or trigger write lands.
- R5: When the counter advances from all-ones, overflow status (bit 1 of 0x018) sets. With auto-reload off, the counter continues from zero. A counter loaded with -N overflows on its N-th step.
- R6: When control bit 1 (auto-reload) is 1, an overflow loads the counter with the committed reload value.
- R7: When control bit 5 is 1, one count step happens every 2^(p+1) ticks, where p is control bits 4:2. The step count restarts when a control write lands. When bit 5 is 0, every tick is a count step.
- R8: When control bit 6 is 1, a count step that brings the counter to the committed compare value sets match status (bit 0 of 0x018).
- R9: Writing to status (0x018) clears exactly the bits written as 1, in the same cycle. Status bits that are not written stay set.
- R10: The interrupt output goes high one cycle after any status bit is set together with its enable bit in 0x01C. The enable register uses the same bit layout as status and takes effect at once.
- R11: When a trigger write lands, the counter loads the committed reload value.
- R12: A counter write that lands on the same tick as a count step wins over the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One timer tick per cycle it is high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data is returned on the next cycle |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt level |

## Verification
The assertions assume the bus issues at most one write per cycle. On that basis, a pending bit can only rise in the cycle after a write. They also assume that `tick_en` is the only thing that lets a held write land, so a pending bit can only fall right after a tick.

The stimulus keeps to these assumptions. It never asserts a read and a write together. It drives `tick_en` only in bursts of a known length, and holds it low while it reads. This way every counter value, pending bit and status bit the bench reads follows from a tick count the bench has computed.

// File: rtl/uptick_pkg.sv
package uptick_pkg;
  localparam int NSLOT  = 5;
  localparam int SL_CTRL = 0;
  localparam int SL_CNT  = 1;
  localparam int SL_RLD  = 2;
  localparam int SL_TRG  = 3;
  localparam int SL_MAT  = 4;

  localparam logic [7:0] A_ID   = 8'h00;
  localparam logic [7:0] A_STAT = 8'h18;
  localparam logic [7:0] A_IEN  = 8'h1C;
  localparam logic [7:0] A_CTRL = 8'h24;
  localparam logic [7:0] A_CNT  = 8'h28;
  localparam logic [7:0] A_RLD  = 8'h2C;
  localparam logic [7:0] A_TRG  = 8'h30;
  localparam logic [7:0] A_PEND = 8'h34;
  localparam logic [7:0] A_MAT  = 8'h38;

  localparam int C_RUN   = 0;
  localparam int C_AUTO  = 1;
  localparam int C_PS_LO = 2;
  localparam int C_PS_HI = 4;
  localparam int C_PSEN  = 5;
  localparam int C_CMP   = 6;

  localparam int NEV    = 3;
  localparam int EV_MAT = 0;
  localparam int EV_OVF = 1;

  function automatic logic [7:0] slot_addr(input int s);
    case (s)
      SL_CTRL: return A_CTRL;
      SL_CNT:  return A_CNT;
      SL_RLD:  return A_RLD;
      SL_TRG:  return A_TRG;
      default: return A_MAT;
    endcase
  endfunction
endpackage

// File: rtl/posted_slot.sv
module posted_slot #(
  parameter int W          = 32,
  parameter int POST_TICKS = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         pend,
  output logic         apply,
  output logic [W-1:0] value
);
  localparam int DLY_W = $clog2(POST_TICKS + 1);

  logic [DLY_W-1:0] left_q;

  assign apply = pend && tick_en && !wr_en && (left_q == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      left_q <= '0;
      value  <= '0;
    end else if (wr_en) begin
      value  <= wdata;
      pend   <= 1'b1;
      left_q <= DLY_W'(POST_TICKS);
    end else if (pend && tick_en) begin
      if (left_q == DLY_W'(1)) pend <= 1'b0;
      else                     left_q <= left_q - DLY_W'(1);
    end
  end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic            run,
  input  logic            ps_en,
  input  logic [PS_W-1:0] ps_val,
  input  logic            restart,
  output logic            fire
);
  localparam int DIV_W = 1 << PS_W;

  logic [DIV_W-1:0] pcnt_q, lim;

  assign lim  = {DIV_W{1'b1}} >> (DIV_W - 1 - int'(ps_val));
  assign fire = run && tick_en && (!ps_en || (pcnt_q == lim));

  always_ff @(posedge clk) begin
    if (rst || restart || !run)
      pcnt_q <= '0;
    else if (tick_en && ps_en)
      pcnt_q <= (pcnt_q == lim) ? '0 : pcnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         autoreload,
  input  logic         cmp_en,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] match_val,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         ovf_ev,
  output logic         mat_ev
);
  logic         at_top;
  logic [W-1:0] nxt;

  assign at_top = (count == {W{1'b1}});
  assign nxt    = at_top ? (autoreload ? reload : '0) : count + W'(1);
  assign ovf_ev = adv && !load_en && at_top;
  assign mat_ev = adv && !load_en && cmp_en && (nxt == match_val);

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (load_en) count <= load_val;
    else if (adv)     count <= nxt;
  end
endmodule

// File: rtl/uptick_timer.sv
module uptick_timer
  import uptick_pkg::*;
#(
  parameter int         DATA_W     = 32,
  parameter int         ADDR_W     = 8,
  parameter int         POST_TICKS = 3,
  parameter logic [3:0] REV_MAJOR  = 4'd2,
  parameter logic [3:0] REV_MINOR  = 4'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PS_W = C_PS_HI - C_PS_LO + 1;

  logic [NSLOT-1:0]  pend, apply;
  logic [DATA_W-1:0] hold [NSLOT];
  logic [DATA_W-1:0] ctrl_q, reload_q, match_q, count_q, load_val, rd_mux;
  logic [NEV-1:0]    stat_q, ien_q, ev, clr;
  logic              load_en, adv, ovf_ev, mat_ev, stat_wr, ien_wr;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(slot_addr(s)));
    posted_slot #(.W(DATA_W), .POST_TICKS(POST_TICKS)) u_post (
      .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(hit), .wdata(wdata),
      .pend(pend[s]), .apply(apply[s]), .value(hold[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      match_q  <= '0;
    end else begin
      if (apply[SL_CTRL]) ctrl_q   <= hold[SL_CTRL];
      if (apply[SL_RLD])  reload_q <= hold[SL_RLD];
      if (apply[SL_MAT])  match_q  <= hold[SL_MAT];
    end
  end

  assign load_en  = apply[SL_CNT] | apply[SL_TRG];
  assign load_val = apply[SL_CNT] ? hold[SL_CNT] : reload_q;

  tick_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .tick_en(tick_en), .run(ctrl_q[C_RUN]),
    .ps_en(ctrl_q[C_PSEN]), .ps_val(ctrl_q[C_PS_HI:C_PS_LO]),
    .restart(apply[SL_CTRL]), .fire(adv)
  );

  count_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .adv(adv), .autoreload(ctrl_q[C_AUTO]),
    .cmp_en(ctrl_q[C_CMP]), .reload(reload_q), .match_val(match_q),
    .load_en(load_en), .load_val(load_val), .count(count_q),
    .ovf_ev(ovf_ev), .mat_ev(mat_ev)
  );

  assign stat_wr = wr_en && (addr == ADDR_W'(A_STAT));
  assign ien_wr  = wr_en && (addr == ADDR_W'(A_IEN));
  assign clr     = stat_wr ? wdata[NEV-1:0] : '0;

  always_comb begin
    ev         = '0;
    ev[EV_OVF] = ovf_ev;
    ev[EV_MAT] = mat_ev;
  end

  always_comb begin
    case (addr)
      ADDR_W'(A_ID):   rd_mux = {{(DATA_W-8){1'b0}}, REV_MAJOR, REV_MINOR};
      ADDR_W'(A_STAT): rd_mux = DATA_W'(stat_q);
      ADDR_W'(A_IEN):  rd_mux = DATA_W'(ien_q);
      ADDR_W'(A_CTRL): rd_mux = ctrl_q;
      ADDR_W'(A_CNT):  rd_mux = count_q;
      ADDR_W'(A_RLD):  rd_mux = reload_q;
      ADDR_W'(A_TRG):  rd_mux = hold[SL_TRG];
      ADDR_W'(A_PEND): rd_mux = DATA_W'(pend);
      ADDR_W'(A_MAT):  rd_mux = match_q;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ien_q  <= '0;
      irq    <= 1'b0;
      rdata  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | ev;
      if (ien_wr) ien_q <= wdata[NEV-1:0];
      irq <= |(stat_q & ien_q);
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/uptick_timer_checker.sv
module uptick_timer_checker #(
  parameter int W  = 32,
  parameter int NS = 5,
  parameter int NE = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_en,
  input logic          wr_en,
  input logic          irq,
  input logic          run,
  input logic          load_en,
  input logic [NS-1:0] pend,
  input logic [NE-1:0] stat,
  input logic [NE-1:0] ien,
  input logic [W-1:0]  count
);
  // R2: a held write lands only on a tick
  a_r2_pend_falls_on_tick: assert property (@(posedge clk) disable iff (rst)
    ((~pend & $past(pend)) != '0) |-> $past(tick_en));

  // R2: a pending bit appears only after a write, one at a time
  a_r2_pend_rises_on_write: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend)) != '0) |-> ($past(wr_en) && $onehot0(pend & ~$past(pend))));

  // R4: a stopped counter with nothing landing keeps its value
  a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_en) |=> $stable(count));

  // R5: overflow status rises only after the counter sat at all-ones
  a_r5_ovf_from_ones: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[1]) |-> ($past(count) == {W{1'b1}}));

  // R9: status bits only drop after a bus write
  a_r9_clear_needs_write: assert property (@(posedge clk) disable iff (rst)
    ((~stat & $past(stat)) != '0) |-> $past(wr_en));

  // R10: interrupt needs an enable bit in the previous cycle
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ien) != '0));
endmodule

bind uptick_timer uptick_timer_checker #(.W(DATA_W), .NS(uptick_pkg::NSLOT), .NE(uptick_pkg::NEV)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .irq(irq),
  .run(ctrl_q[0]), .load_en(load_en), .pend(pend), .stat(stat_q),
  .ien(ien_q), .count(count_q)
);

// File: tb/uptick_timer_bench.sv
module uptick_timer_bench;
  localparam int POST = 3;

  logic        clk = 1'b0, rst = 1'b1, tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_tests = 0, n_fail = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  uptick_timer u_uptick_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic int step_div(input bit pe, input int p);
    return pe ? (1 << (p + 1)) : 1;
  endfunction

  function automatic logic [31:0] ctrl_word(input bit run, ar, pe, input int p, input bit cmp);
    return {25'd0, cmp, pe, 3'(p), ar, run};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
    end
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20250611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(1);
    check("reset irq", {31'd0, irq}, 32'd0);
    br(8'h34, rv); check("reset pending", rv, 32'd0);
    br(8'h28, rv); check("reset counter", rv, 32'd0);

    // R1
    br(8'h00, rv); check("R1 revision", rv, 32'h21);

    // R2 posted reload
    bw(8'h2C, 32'h1234_5678);
    br(8'h34, rv); check("R2 pending reload", rv, 32'h4);
    br(8'h2C, rv); check("R2 old value held", rv, 32'd0);
    ticks(POST - 1);
    br(8'h34, rv); check("R2 still pending", rv, 32'h4);
    ticks(1);
    br(8'h34, rv); check("R2 pending cleared", rv, 32'd0);
    br(8'h2C, rv); check("R2 value landed", rv, 32'h1234_5678);

    // R3 rewrite restarts delay
    bw(8'h2C, 32'hAAAA_0001);
    ticks(POST - 1);
    bw(8'h2C, 32'h5555_0002);
    ticks(POST - 1);
    br(8'h34, rv); check("R3 restart pending", rv, 32'h4);
    br(8'h2C, rv); check("R3 old value kept", rv, 32'h1234_5678);
    ticks(1);
    br(8'h2C, rv); check("R3 replaced value", rv, 32'h5555_0002);

    // R11 trigger
    bw(8'h30, 32'h0);
    br(8'h34, rv); check("R11 trigger pending", rv, 32'h8);
    ticks(POST);
    br(8'h28, rv); check("R11 trigger loads reload", rv, 32'h5555_0002);

    // R4 count and hold
    bw(8'h28, 32'h10);
    bw(8'h24, ctrl_word(1, 0, 0, 0, 0));
    ticks(POST);
    br(8'h28, rv); check("R4 no step on commit", rv, 32'h10);
    ticks(7);
    br(8'h28, rv); check("R4 counts up", rv, 32'h17);
    bw(8'h24, 32'h0);
    ticks(POST);
    br(8'h28, rv); check("R4 last step before stop", rv, 32'h1A);
    ticks(5);
    br(8'h28, rv); check("R4 holds when stopped", rv, 32'h1A);

    // R5 + R6 auto-reload
    bw(8'h28, 32'hFFFF_FFFD);
    bw(8'h2C, 32'h100);
    bw(8'h24, ctrl_word(1, 1, 0, 0, 0));
    bw(8'h18, 32'h7);
    ticks(POST);
    ticks(2);
    br(8'h18, rv); check("R5 no overflow yet", rv, 32'h0);
    ticks(1);
    br(8'h18, rv); check("R5 overflow set", rv, 32'h2);
    ticks(2);
    br(8'h28, rv); check("R6 reload on wrap", rv, 32'h102);

    // R9 immediate clear
    bw(8'h18, 32'h2);
    br(8'h18, rv); check("R9 cleared", rv, 32'h0);

    // R5 no auto-reload wraps to zero
    bw(8'h28, 32'hFFFF_FFFE);
    bw(8'h24, ctrl_word(1, 0, 0, 0, 0));
    ticks(POST);
    ticks(4);
    br(8'h28, rv); check("R5 wraps to zero", rv, 32'h2);
    br(8'h18, rv); check("R5 overflow no reload", rv, 32'h2);

    // R8 compare, R9 selective clear, R10 irq
    bw(8'h28, 32'h0);
    bw(8'h38, 32'h5);
    bw(8'h24, ctrl_word(1, 0, 0, 0, 1));
    bw(8'h18, 32'h7);
    bw(8'h1C, 32'h2);
    ticks(POST);
    ticks(4);
    br(8'h18, rv); check("R8 no match early", rv, 32'h0);
    ticks(1);
    br(8'h18, rv); check("R8 match set", rv, 32'h1);
    idle(2);
    check("R10 masked irq", {31'd0, irq}, 32'd0);
    bw(8'h18, 32'h2);
    br(8'h18, rv); check("R9 unwritten bit kept", rv, 32'h1);
    bw(8'h1C, 32'h1);
    idle(2);
    check("R10 irq high", {31'd0, irq}, 32'd1);
    bw(8'h18, 32'h1);
    idle(2);
    check("R10 irq low after clear", {31'd0, irq}, 32'd0);

    // R7 prescaler p=1
    bw(8'h28, 32'h0);
    bw(8'h24, ctrl_word(1, 0, 1, 1, 0));
    ticks(POST);
    ticks(9);
    br(8'h28, rv); check("R7 divide by four", rv, 32'h2);
    ticks(3);
    br(8'h28, rv); check("R7 next step", rv, 32'h3);

    // Random: R5 interval, R7 divisor, R12 counter load wins, R2 pending map
    for (int it = 0; it < 8; it++) begin
      int n, p, d;
      bit pe;
      logic [31:0] mv;
      n  = 1 + int'($urandom % 40);
      p  = int'($urandom % 3);
      pe = 1'($urandom);
      mv = $urandom;
      d  = step_div(pe, p);
      bw(8'h24, 32'h0);
      bw(8'h28, -n);
      bw(8'h38, mv);
      bw(8'h18, 32'h7);
      br(8'h34, rv); check("R2 random pending map", rv, 32'h13);
      ticks(POST);
      br(8'h38, rv); check("R2 random compare value", rv, mv);
      br(8'h28, rv); check("R12 load wins over step", rv, -n);
      bw(8'h24, ctrl_word(1, 0, pe, p, 0));
      ticks(POST);
      ticks(n * d - 1);
      br(8'h18, rv); check("R5 random no early overflow", rv, 32'h0);
      ticks(1);
      br(8'h18, rv); check("R7 random overflow on time", rv, 32'h2);
      br(8'h28, rv); check("R5 random counter zero", rv, 32'h0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule